// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous static RAM. The RAM is selected by two chip selects: one active low and one active high. It also has an output-disable input and a read/write strobe. The host makes one request at a time over a valid/ready handshake, giving an address, a write flag and write data. The controller turns each request into a pin-level sequence on the memory side.

A write goes through three phases. The first is an address/select setup phase, during which output-disable is also raised when the data bus is shared. The second is a write-strobe phase. The third is a recovery/hold phase, which is stretched when needed to meet the minimum write-cycle time. A read is one access phase that lasts the longer of the access time and the minimum read cycle; the returned data is sampled on the last cycle of that phase. Every minimum interval is a parameter in clock cycles, rounded up from nanoseconds at the chosen clock period, and each phase is timed by a down-counter.

When an operation finishes, the controller pulses a done signal. For a read, the captured data is presented with that pulse. The memory pins then return to standby. A parameter selects between separate data-in/data-out wiring and a shared bus, for which the controller provides a driver enable for an external three-state buffer.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset and between operations, the memory pins sit in standby: `mem_cs1_n`=1, `mem_cs2`=0, `mem_rw_n`=1, `mem_od`=1, `mem_wdata_oe`=0. `req_ready`=1 and `rsp_done`=0.
- R2: A request is accepted only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the done cycle. A `req_valid` raised while busy is ignored: it changes no pin and writes nothing.
- R3: Throughout an operation, both chip selects are active and `mem_addr` equals the accepted address without change. Before the strobe falls, the select/address setup phase lasts exactly SETUP cycles. SETUP is the address-setup count, or the larger of the address-setup and output-disable-setup counts when the bus is shared.
- R4: With a shared bus, `mem_od` is 1 for every cycle of a write. `mem_wdata_oe` is 1 only while `mem_od` is 1, so the driver is never on while the memory drives the bus.
- R5: `mem_rw_n` is 0 for exactly max(write-pulse, data-setup) cycles. During all of those cycles `mem_wdata_oe`=1 and `mem_wdata` equals the accepted write data.
- R6: After `mem_rw_n` rises, address, chip selects and write data stay unchanged for at least max(recovery, data-hold) cycles before standby.
- R7: The selected portion of a write (setup + strobe + hold) lasts exactly max(SETUP + strobe + max(recovery, data-hold), write-cycle) cycles.
- R8: A read keeps `mem_rw_n`=1, `mem_od`=0 and the chip selected for exactly max(access, read-cycle) cycles. It samples `mem_rdata` on the final cycle of that window.
- R9: `rsp_done` is a single-cycle pulse in the first cycle after the last phase cycle. `req_ready`=1 in that cycle, and for a read `rsp_rdata` holds the sampled data.
- R10: Data written through the controller reads back through the controller from the same address, and other addresses are not modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_od | output | 1 | Output disable, 1 = memory outputs off |
| mem_rw_n | output | 1 | Read/write strobe, 0 = write |
| mem_wdata | output | DATA_W | Data toward memory |
| mem_wdata_oe | output | 1 | Enable of the external data driver |
| mem_rdata | input | DATA_W | Data from memory |

## Verification
The hardest situation to reach from the ports is a request raised while the controller is busy. Such a request must leave both the pins and the array untouched. The stimulus reaches it by holding `req_valid` high with an unrelated address and the write flag set during the whole of some operations. It then reads the unrelated address back through the controller. A second difficult case is a capture that happens before the access time has elapsed. The memory model presents inverted data until the address has been stable and the outputs enabled for the access count, so an early capture shows up as a data mismatch. The write-cycle stretch of the hold phase is reached by giving the bench a write-cycle count larger than the sum of the other write intervals.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_SETUP   = 3'd1,
      PH_STROBE  = 3'd2,
      PH_RECOVER = 3'd3,
      PH_ACCESS  = 3'd4
   } phase_e;

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
   import sram_ctrl_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int SETUP_LEN  = 1,
   parameter int STROBE_LEN = 1,
   parameter int HOLD_LEN   = 1,
   parameter int ACCESS_LEN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_write,
   input  logic             expired,
   output phase_e           phase,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             finish
);
   localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_LEN - 1);
   localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_LEN - 1);
   localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_LEN - 1);
   localparam logic [CNT_W-1:0] ACCESS_LD = CNT_W'(ACCESS_LEN - 1);

   phase_e phase_q, phase_d;

   always_comb begin
      phase_d  = phase_q;
      load     = 1'b0;
      load_val = '0;
      case (phase_q)
         PH_IDLE: if (start) begin
            load = 1'b1;
            if (start_write) begin
               phase_d  = PH_SETUP;
               load_val = SETUP_LD;
            end else begin
               phase_d  = PH_ACCESS;
               load_val = ACCESS_LD;
            end
         end
         PH_SETUP: if (expired) begin
            phase_d  = PH_STROBE;
            load     = 1'b1;
            load_val = STROBE_LD;
         end
         PH_STROBE: if (expired) begin
            phase_d  = PH_RECOVER;
            load     = 1'b1;
            load_val = HOLD_LD;
         end
         PH_RECOVER: if (expired) phase_d = PH_IDLE;
         PH_ACCESS:  if (expired) phase_d = PH_IDLE;
         default:    phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase  = phase_q;
   assign finish = expired && ((phase_q == PH_RECOVER) || (phase_q == PH_ACCESS));
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 4,
   parameter bit SHARED_BUS = 1'b0
) (
   input  phase_e            phase,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] data_q,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_od,
   output logic              mem_rw_n,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_wdata_oe
);
   logic selected;

   assign selected  = (phase != PH_IDLE);
   assign mem_cs1_n = ~selected;
   assign mem_cs2   = selected;
   assign mem_rw_n  = (phase != PH_STROBE);
   assign mem_addr  = addr_q;
   assign mem_wdata = data_q;

   generate
      if (SHARED_BUS) begin : g_shared
         // memory outputs off for the whole write; drive only from the strobe on
         assign mem_od       = (phase != PH_ACCESS);
         assign mem_wdata_oe = (phase == PH_STROBE) || (phase == PH_RECOVER);
      end else begin : g_split
         // separate wires: memory outputs stay on while selected, data presented early
         assign mem_od       = (phase == PH_IDLE);
         assign mem_wdata_oe = (phase == PH_SETUP) || (phase == PH_STROBE) ||
                               (phase == PH_RECOVER);
      end
   endgenerate
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 4,
   parameter bit SHARED_BUS     = 1'b0,
   parameter int CYC_ADDR_SETUP = 14,
   parameter int CYC_OD_SETUP   = 14,
   parameter int CYC_WR_PULSE   = 19,
   parameter int CYC_DATA_SETUP = 19,
   parameter int CYC_DATA_HOLD  = 5,
   parameter int CYC_WR_RECOVER = 5,
   parameter int CYC_WR_CYCLE   = 38,
   parameter int CYC_RD_ACCESS  = 32,
   parameter int CYC_RD_CYCLE   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_od,
   output logic              mem_rw_n,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_wdata_oe,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int SETUP_LEN  = SHARED_BUS ? int'(imax(CYC_ADDR_SETUP, CYC_OD_SETUP))
                                          : CYC_ADDR_SETUP;
   localparam int STROBE_LEN = int'(imax(CYC_WR_PULSE, CYC_DATA_SETUP));
   localparam int HOLD_BASE  = int'(imax(CYC_WR_RECOVER, CYC_DATA_HOLD));
   localparam int HOLD_LEN   = (SETUP_LEN + STROBE_LEN + HOLD_BASE >= CYC_WR_CYCLE)
                               ? HOLD_BASE : CYC_WR_CYCLE - SETUP_LEN - STROBE_LEN;
   localparam int ACCESS_LEN = int'(imax(CYC_RD_ACCESS, CYC_RD_CYCLE));
   localparam int MAX_LEN    = int'(imax(imax(SETUP_LEN, STROBE_LEN),
                                         imax(HOLD_LEN, ACCESS_LEN)));
   localparam int CNT_W      = $clog2(MAX_LEN + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_cycle_ctrl: ADDR_W and DATA_W must be at least 1");
      end
      if (CYC_ADDR_SETUP < 1 || CYC_OD_SETUP < 1 || CYC_WR_PULSE < 1 ||
          CYC_DATA_SETUP < 1 || CYC_DATA_HOLD < 1 || CYC_WR_RECOVER < 1 ||
          CYC_WR_CYCLE < 1 || CYC_RD_ACCESS < 1 || CYC_RD_CYCLE < 1) begin : g_bad_timing
         $error("sram_cycle_ctrl: every interval count must be at least 1");
      end
   endgenerate

   phase_e            phase;
   logic              start, load, expired, finish;
   logic [CNT_W-1:0]  load_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q, rdata_q;
   logic              done_q;

   assign req_ready = (phase == PH_IDLE);
   assign start     = req_valid && req_ready;

   sram_phase_seq #(
      .CNT_W(CNT_W), .SETUP_LEN(SETUP_LEN), .STROBE_LEN(STROBE_LEN),
      .HOLD_LEN(HOLD_LEN), .ACCESS_LEN(ACCESS_LEN)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_write(req_write),
      .expired(expired), .phase(phase), .load(load), .load_val(load_val),
      .finish(finish)
   );

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         data_q  <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         if (start) begin
            addr_q <= req_addr;
            data_q <= req_wdata;
         end
         if (phase == PH_ACCESS && expired) rdata_q <= mem_rdata;
         done_q <= finish;
      end
   end

   assign rsp_done  = done_q;
   assign rsp_rdata = rdata_q;

   sram_pin_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHARED_BUS(SHARED_BUS)
   ) u_pins (
      .phase(phase), .addr_q(addr_q), .data_q(data_q),
      .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
      .mem_od(mem_od), .mem_rw_n(mem_rw_n), .mem_wdata(mem_wdata),
      .mem_wdata_oe(mem_wdata_oe)
   );
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 4,
   parameter bit SHARED_BUS = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs1_n,
   input logic              mem_cs2,
   input logic              mem_od,
   input logic              mem_rw_n,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_wdata_oe
);
   assert_standby_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs1_n && !mem_cs2 && mem_rw_n && mem_od && !mem_wdata_oe));

   assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_strobe_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rw_n |-> (!mem_cs1_n && mem_cs2));

   assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

   assert_wdata_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rw_n && $past(!mem_rw_n)) |-> $stable(mem_wdata));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   generate
      if (SHARED_BUS) begin : g_shared_chk
         assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
            mem_wdata_oe |-> mem_od);
         assert_od_during_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !mem_rw_n |-> mem_od);
      end
   endgenerate
endmodule

bind sram_cycle_ctrl sram_ctrl_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHARED_BUS(SHARED_BUS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_done(rsp_done), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
   .mem_cs2(mem_cs2), .mem_od(mem_od), .mem_rw_n(mem_rw_n),
   .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe)
);

// File: tb/tb_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_sram_cycle_ctrl;
   localparam int AW = 8, DW = 4;
   localparam int T_AS = 3, T_OD = 5, T_WP = 4, T_DS = 6, T_DH = 2, T_REC = 3;
   localparam int T_WC = 20, T_ACC = 5, T_RC = 7;

   function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction
   function automatic int exp_setup();  return mx(T_AS, T_OD); endfunction
   function automatic int exp_strobe(); return mx(T_WP, T_DS); endfunction
   function automatic int exp_hold();
      int base;
      base = mx(T_REC, T_DH);
      return mx(base, T_WC - exp_setup() - exp_strobe());
   endfunction
   function automatic int exp_access(); return mx(T_ACC, T_RC); endfunction

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_done, mem_cs1_n, mem_cs2, mem_od, mem_rw_n, mem_wdata_oe;
   logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
   logic [AW-1:0] mem_addr;

   int checks = 0, errors = 0, cyc = 0;
   logic [DW-1:0] pmem   [0:(1<<AW)-1];
   logic [DW-1:0] shadow [0:(1<<AW)-1];
   int age = 0;
   logic rw_prev = 1'b1;
   logic [AW-1:0] last_addr = '0;

   always #4 clk = ~clk;

   sram_cycle_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .SHARED_BUS(1'b1),
      .CYC_ADDR_SETUP(T_AS), .CYC_OD_SETUP(T_OD), .CYC_WR_PULSE(T_WP),
      .CYC_DATA_SETUP(T_DS), .CYC_DATA_HOLD(T_DH), .CYC_WR_RECOVER(T_REC),
      .CYC_WR_CYCLE(T_WC), .CYC_RD_ACCESS(T_ACC), .CYC_RD_CYCLE(T_RC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_od(mem_od),
      .mem_rw_n(mem_rw_n), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
      .mem_rdata(mem_rdata)
   );

   // memory model: writes on strobe rise, read data wrong until access time has elapsed
   assign mem_rdata = (age >= T_ACC) ? pmem[mem_addr] : ~pmem[mem_addr];

   always @(negedge clk) begin
      if (!mem_cs1_n && mem_cs2 && !mem_od && mem_rw_n && mem_addr == last_addr)
         age <= age + 1;
      else if (!mem_cs1_n && mem_cs2 && !mem_od && mem_rw_n)
         age <= 1;
      else
         age <= 0;
      last_addr <= mem_addr;
      if (!rw_prev && mem_rw_n && !mem_cs1_n && mem_cs2)
         pmem[mem_addr] <= mem_wdata;
      rw_prev <= mem_rw_n;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL R2 watchdog actual=%0d expected<=%0d", cyc, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_standby(input string tag);
      chk(mem_cs1_n == 1'b1 && mem_cs2 == 1'b0 && mem_rw_n == 1'b1 && mem_od == 1'b1 &&
          mem_wdata_oe == 1'b0 && req_ready == 1'b1,
          tag, {mem_cs1_n, mem_cs2, mem_rw_n, mem_od, mem_wdata_oe, req_ready}, 6'b101101);
   endtask

   task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit noise);
      int n, setup, od_pre, strobe, hold, sel, od_low, addr_bad, data_bad, oe_bad, busy_rdy;
      bit seen_low;
      @(negedge clk);
      chk(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      n = 0; setup = 0; od_pre = 0; strobe = 0; hold = 0; sel = 0; od_low = 0;
      addr_bad = 0; data_bad = 0; oe_bad = 0; busy_rdy = 0; seen_low = 1'b0;
      if (noise) begin
         req_valid = 1'b1; req_write = 1'b1; req_addr = ~a; req_wdata = ~d;
      end else req_valid = 1'b0;
      while (!rsp_done && n < 300) begin
         if (req_ready) busy_rdy++;
         if (!mem_cs1_n && mem_cs2) begin
            sel++;
            if (mem_addr != a) addr_bad++;
            if (!mem_od) od_low++;
            if (!mem_rw_n) begin
               strobe++; seen_low = 1'b1;
               if (!mem_wdata_oe || mem_wdata != d) data_bad++;
            end else if (!seen_low) begin
               setup++;
               if (mem_od) od_pre++;
            end else begin
               hold++;
               if (!mem_wdata_oe || mem_wdata != d) data_bad++;
            end
         end
         if (mem_wdata_oe && !mem_od) oe_bad++;
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      chk(rsp_done == 1'b1, "R9 done seen", rsp_done, 1);
      chk(busy_rdy == 0, "R2 ready low while busy", busy_rdy, 0);
      chk(addr_bad == 0, "R3 address held", addr_bad, 0);
      chk(req_ready == 1'b1, "R9 ready in done cycle", req_ready, 1);
      if (wr) begin
         chk(setup == exp_setup(), "R3 setup length", setup, exp_setup());
         chk(od_pre == setup && od_pre >= T_OD, "R4 od setup before strobe", od_pre, setup);
         chk(oe_bad == 0 && od_low == 0, "R4 no driver contention", oe_bad + od_low, 0);
         chk(strobe == exp_strobe(), "R5 strobe length", strobe, exp_strobe());
         chk(data_bad == 0, "R5 R6 data held", data_bad, 0);
         chk(hold == exp_hold() && hold >= mx(T_REC, T_DH), "R6 hold length", hold, exp_hold());
         chk(sel == exp_setup() + exp_strobe() + exp_hold() && sel >= T_WC,
             "R7 write cycle length", sel, exp_setup() + exp_strobe() + exp_hold());
         shadow[a] = d;
      end else begin
         chk(strobe == 0, "R8 no strobe on read", strobe, 0);
         chk(sel == exp_access() && od_low == exp_access(), "R8 access length",
             sel, exp_access());
         chk(rsp_rdata == shadow[a], "R8 R10 read data", rsp_rdata, shadow[a]);
      end
      @(negedge clk);
      chk(rsp_done == 1'b0, "R9 done single pulse", rsp_done, 0);
      check_standby("R1 standby after op");
   endtask

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < (1 << AW); i++) begin
         pmem[i] = '0;
         shadow[i] = '0;
      end
      repeat (3) @(negedge clk);
      check_standby("R1 standby in reset");
      chk(rsp_done == 1'b0, "R1 done low in reset", rsp_done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_standby("R1 standby after reset");

      // directed corners
      do_op(1'b1, 8'h00, 4'hA, 1'b0);
      do_op(1'b1, 8'hFF, 4'h5, 1'b0);
      do_op(1'b0, 8'h00, 4'h0, 1'b0);
      do_op(1'b0, 8'hFF, 4'h0, 1'b0);
      do_op(1'b1, 8'h33, 4'h6, 1'b1);    // R2: busy-time request with ~addr ignored
      do_op(1'b0, 8'hCC, 4'h0, 1'b0);    // R10: 0xCC untouched
      do_op(1'b0, 8'h33, 4'h0, 1'b1);
      do_op(1'b0, 8'hCC, 4'h0, 1'b0);

      for (int k = 0; k < 80; k++) begin
         do_op(1'($urandom % 2), AW'($urandom), DW'($urandom), ($urandom % 4) == 0);
      end
      for (int k = 0; k < 16; k++) do_op(1'b0, AW'(k * 17), 4'h0, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule